// File: doc/BRIEF.md
# Variable-rate client-to-frame mapper

This block places a continuous stream of client words into the fixed payload region of a periodic server frame. The client stream and the server frame run at independent rates. Their crossing is modelled here with one clock: a valid strobe marks each client word, and three strobes mark the server frame timing (frame start, overhead slot, payload slot). Every client word that arrives goes into a small buffer. Words leave the buffer only through payload slots that the current frame has chosen to carry data.

At each frame start the block fixes a count for the whole frame. The count is the buffer fill at that instant, limited to the payload size. The count goes out in the frame's overhead slots as a two-byte field, most significant byte first. The same number of buffered words is then spread evenly over the payload positions, and every other position carries zero stuff.

Because the count follows the fill directly in every frame, the block reaches the right count in one frame after start-up or after a step in the client rate. A sticky flag reports a client word that found the buffer full.

Top module: `vrate_mapper`

## Requirements
- R1: After reset the server output is zero, the overflow flag is low and the buffer is empty, so the first frame carries a count of zero.
- R2: Every client word presented with valid while the buffer has room is stored, and stored words leave in arrival order.
- R3: On a frame start the frame's count becomes the buffer fill at that edge, limited to PAYLOAD_N (16 by default).
- R4: The first overhead slot after a frame start outputs bits 15:8 of the 16-bit count field and the second outputs bits 7:0. Any further overhead slot in that frame outputs zero.
- R5: Payload position j (1 to PAYLOAD_N, counted from the frame start) carries the next buffered word when (j*count mod PAYLOAD_N) < count, and carries zero otherwise.
- R6: The count stays fixed for the whole frame, so words that arrive after the frame start do not change that frame's overhead or its data positions.
- R7: Cycles with no slot strobe, and payload slots beyond position PAYLOAD_N, output zero.
- R8: A client word that arrives while the buffer holds BUF_DEPTH words and no word leaves in that cycle is dropped and sets the overflow flag, which then stays high until reset.
- R9: The count has no smoothing. The first frame start after a step in the fill, including the step at start-up, already carries the new fill as its count.
- R10: The output for a slot strobe appears on the server output in the clock cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by the client and server sides |
| rst_n | input | 1 | Active-low synchronous reset |
| cli_valid | input | 1 | A client word is present this cycle |
| cli_data | input | DATA_W | Client word |
| frm_start | input | 1 | Server frame starts; the count is fixed here |
| oh_slot | input | 1 | Overhead position strobe |
| pl_slot | input | 1 | Payload position strobe |
| srv_data | output | DATA_W | Server word, registered |
| ovf_flag | output | 1 | Sticky flag for a dropped client word |

## Verification
The bench builds the block with DATA_W 8, PAYLOAD_N 16, OH_N 2 and BUF_DEPTH 24. Because the buffer is deeper than the payload, the fill can exceed 16 and the count limit of R3 can be reached, and a frame can leave words behind for the next frame. With a 16-word payload the distribution rule is exercised for counts 0, 1, odd, even and full. The deeper buffer also lets the bench drive 24 words and then one more to reach the overflow drop, and then drain the buffer to show that the dropped word never appears.

// File: rtl/vrate_map_pkg.sv
package vrate_map_pkg;

   typedef enum logic [1:0] {
      SRC_STUFF = 2'd0,
      SRC_OH    = 2'd1,
      SRC_DATA  = 2'd2
   } out_src_e;

   function automatic int unsigned clamp_to(input int unsigned v, input int unsigned lim);
      return (v > lim) ? lim : v;
   endfunction

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/map_fifo.sv
module map_fifo #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         push,
   input  logic [DATA_W-1:0]            wdata,
   input  logic                         pop,
   output logic [DATA_W-1:0]            rdata,
   output logic [$clog2(DEPTH+1)-1:0]   fill,
   output logic                         ovf
);
   import vrate_map_pkg::*;

   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int FW = $clog2(DEPTH + 1);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [FW-1:0]     fill_q;
   logic              is_full, do_wr, do_rd;

   assign is_full = (fill_q == FW'(DEPTH));
   assign do_rd   = pop && (fill_q != '0);
   assign do_wr   = push && (!is_full || do_rd);

   generate
      if (is_pow2(DEPTH)) begin : g_wrap_nat
         assign wr_nxt = wr_ptr + AW'(1);
         assign rd_nxt = rd_ptr + AW'(1);
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
         assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_wr) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         fill_q <= '0;
         ovf    <= 1'b0;
      end else begin
         if (do_wr) wr_ptr <= wr_nxt;
         if (do_rd) rd_ptr <= rd_nxt;
         case ({do_wr, do_rd})
            2'b10:   fill_q <= fill_q + FW'(1);
            2'b01:   fill_q <= fill_q - FW'(1);
            default: fill_q <= fill_q;
         endcase
         if (push && !do_wr) ovf <= 1'b1;
      end
   end

   assign rdata = mem[rd_ptr];
   assign fill  = fill_q;

endmodule

// File: rtl/map_count.sv
module map_count #(
   parameter int PAYLOAD_N = 16,
   parameter int FW        = 5,
   parameter int CW        = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [FW-1:0] fill,
   output logic [CW-1:0] cn
);
   import vrate_map_pkg::*;

   logic [CW-1:0] limited;

   always_comb begin
      limited = CW'(clamp_to(int'(fill), PAYLOAD_N));
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    cn <= '0;
      else if (load) cn <= limited;
   end

endmodule

// File: rtl/map_spread.sv
module map_spread #(
   parameter int PAYLOAD_N = 16,
   parameter int CW        = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   input  logic          step,
   input  logic [CW-1:0] cn,
   output logic          take
);
   import vrate_map_pkg::*;

   localparam int PW = $clog2(PAYLOAD_N + 1);

   logic [PW-1:0] pos;
   logic [CW-1:0] acc, acc_nxt;
   logic [CW:0]   sum;
   logic          live;

   assign live = (pos < PW'(PAYLOAD_N));
   assign sum  = {1'b0, acc} + {1'b0, cn};

   generate
      if (is_pow2(PAYLOAD_N)) begin : g_mod_mask
         assign acc_nxt = CW'(sum & (CW+1)'(PAYLOAD_N - 1));
      end else begin : g_mod_sub
         assign acc_nxt = (sum >= (CW+1)'(PAYLOAD_N)) ?
                          CW'(sum - (CW+1)'(PAYLOAD_N)) : CW'(sum);
      end
   endgenerate

   assign take = step && live && (acc_nxt < cn);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos <= PW'(PAYLOAD_N);
         acc <= '0;
      end else if (restart) begin
         pos <= '0;
         acc <= '0;
      end else if (step && live) begin
         pos <= pos + PW'(1);
         acc <= acc_nxt;
      end
   end

endmodule

// File: rtl/vrate_mapper.sv
module vrate_mapper #(
   parameter int DATA_W    = 8,
   parameter int PAYLOAD_N = 16,
   parameter int BUF_DEPTH = 16,
   parameter int OH_N      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cli_valid,
   input  logic [DATA_W-1:0] cli_data,
   input  logic              frm_start,
   input  logic              oh_slot,
   input  logic              pl_slot,
   output logic [DATA_W-1:0] srv_data,
   output logic              ovf_flag
);
   import vrate_map_pkg::*;

   localparam int CW      = $clog2(PAYLOAD_N + 1);
   localparam int FW      = $clog2(BUF_DEPTH + 1);
   localparam int FIELD_W = OH_N * DATA_W;
   localparam int OHW     = $clog2(OH_N + 1);

   generate
      if (PAYLOAD_N < 2)  begin : g_bad_p   $error("PAYLOAD_N must be at least 2"); end
      if (BUF_DEPTH < 1)  begin : g_bad_d   $error("BUF_DEPTH must be at least 1"); end
      if (OH_N < 1)       begin : g_bad_oh  $error("OH_N must be at least 1"); end
      if (CW > FIELD_W)   begin : g_bad_fw  $error("count does not fit the overhead field"); end
   endgenerate

   logic              step, oh_go, take;
   logic [FW-1:0]     fill;
   logic [CW-1:0]     cn_q;
   logic [DATA_W-1:0] head;
   logic [FIELD_W-1:0] field;
   logic [DATA_W-1:0] oh_bytes [OH_N];
   logic [DATA_W-1:0] oh_byte;
   logic [OHW-1:0]    oh_idx;
   logic [DATA_W-1:0] srv_q;
   out_src_e          src;

   assign step  = pl_slot && !frm_start;
   assign oh_go = oh_slot && !frm_start && !pl_slot;

   map_fifo #(.DATA_W(DATA_W), .DEPTH(BUF_DEPTH)) u_buf (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (cli_valid),
      .wdata (cli_data),
      .pop   (take),
      .rdata (head),
      .fill  (fill),
      .ovf   (ovf_flag)
   );

   map_count #(.PAYLOAD_N(PAYLOAD_N), .FW(FW), .CW(CW)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (frm_start),
      .fill  (fill),
      .cn    (cn_q)
   );

   map_spread #(.PAYLOAD_N(PAYLOAD_N), .CW(CW)) u_spr (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (frm_start),
      .step    (step),
      .cn      (cn_q),
      .take    (take)
   );

   assign field = FIELD_W'(cn_q);

   genvar k;
   generate
      for (k = 0; k < OH_N; k++) begin : g_ohb
         assign oh_bytes[k] = field[(OH_N-1-k)*DATA_W +: DATA_W];
      end
   endgenerate

   always_comb begin
      oh_byte = '0;
      for (int i = 0; i < OH_N; i++) begin
         if (oh_idx == OHW'(i)) oh_byte = oh_bytes[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                            oh_idx <= OHW'(OH_N);
      else if (frm_start)                    oh_idx <= '0;
      else if (oh_go && oh_idx < OHW'(OH_N)) oh_idx <= oh_idx + OHW'(1);
   end

   always_comb begin
      src = SRC_STUFF;
      if (oh_go && oh_idx < OHW'(OH_N)) src = SRC_OH;
      else if (take)                    src = SRC_DATA;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) srv_q <= '0;
      else begin
         case (src)
            SRC_OH:   srv_q <= oh_byte;
            SRC_DATA: srv_q <= head;
            default:  srv_q <= '0;
         endcase
      end
   end

   assign srv_data = srv_q;

endmodule

// File: rtl/vrate_mapper_chk.sv
module vrate_mapper_chk #(
   parameter int DATA_W    = 8,
   parameter int PAYLOAD_N = 16,
   parameter int BUF_DEPTH = 16,
   parameter int CW        = 5,
   parameter int FW        = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cli_valid,
   input logic              frm_start,
   input logic              oh_slot,
   input logic              pl_slot,
   input logic [DATA_W-1:0] srv_data,
   input logic              ovf_flag,
   input logic [CW-1:0]     cn,
   input logic [FW-1:0]     fill,
   input logic              pop
);

   a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_flag |=> ovf_flag);

   a_r8_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_flag) |-> ($past(cli_valid) && ($past(fill) == FW'(BUF_DEPTH))));

   a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (!oh_slot && !pl_slot) |=> (srv_data == '0));

   a_r6_cn_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !frm_start |=> $stable(cn));

   a_r3_cn_from_fill: assert property (@(posedge clk) disable iff (!rst_n)
      frm_start |=> ((int'(cn) <= PAYLOAD_N) &&
                     (int'(cn) == ((int'($past(fill)) > PAYLOAD_N) ? PAYLOAD_N : int'($past(fill))))));

   a_r5_no_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (fill != '0));

endmodule

bind vrate_mapper vrate_mapper_chk #(
   .DATA_W    (DATA_W),
   .PAYLOAD_N (PAYLOAD_N),
   .BUF_DEPTH (BUF_DEPTH),
   .CW        (CW),
   .FW        (FW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cli_valid (cli_valid),
   .frm_start (frm_start),
   .oh_slot   (oh_slot),
   .pl_slot   (pl_slot),
   .srv_data  (srv_data),
   .ovf_flag  (ovf_flag),
   .cn        (cn_q),
   .fill      (fill),
   .pop       (take)
);

// File: tb/sim_vrate_mapper.sv
module sim_vrate_mapper;

   localparam int CLK_PERIOD = 10;
   localparam int W     = 8;
   localparam int P     = 16;
   localparam int DEPTH = 24;
   localparam int OHN   = 2;

   // table: {words pushed before frame, expected count}
   localparam int VEC_N = 10;
   localparam int VEC [VEC_N][2] = '{
      '{0, 0}, '{1, 1}, '{3, 3}, '{5, 5}, '{8, 8},
      '{11, 11}, '{16, 16}, '{20, 16}, '{0, 4}, '{7, 7}
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cli_valid = 1'b0;
   logic [W-1:0] cli_data = '0;
   logic         frm_start = 1'b0;
   logic         oh_slot = 1'b0;
   logic         pl_slot = 1'b0;
   logic [W-1:0] srv_data;
   logic         ovf_flag;

   int tests = 0;
   int fails = 0;
   logic [W-1:0] mq [256];
   int mh = 0, mt = 0;
   logic [W-1:0] next_val = 8'h01;

   always #(CLK_PERIOD/2) clk = ~clk;

   vrate_mapper #(.DATA_W(W), .PAYLOAD_N(P), .BUF_DEPTH(DEPTH), .OH_N(OHN)) u0 (
      .clk(clk), .rst_n(rst_n), .cli_valid(cli_valid), .cli_data(cli_data),
      .frm_start(frm_start), .oh_slot(oh_slot), .pl_slot(pl_slot),
      .srv_data(srv_data), .ovf_flag(ovf_flag)
   );

   task automatic check(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; cli_valid = 1'b0; frm_start = 1'b0; oh_slot = 1'b0; pl_slot = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      mh = 0; mt = 0;
   endtask

   task automatic push_word();
      @(negedge clk);
      cli_valid = 1'b1; cli_data = next_val;
      if (mt - mh < DEPTH) begin
         mq[mt % 256] = next_val;
         mt++;
      end
      next_val = (next_val == 8'hFF) ? 8'h01 : next_val + 8'h01;
      @(negedge clk);
      cli_valid = 1'b0;
   endtask

   task automatic slot(input bit is_oh, output logic [W-1:0] got);
      @(negedge clk);
      oh_slot = is_oh; pl_slot = !is_oh;
      @(negedge clk);
      oh_slot = 1'b0; pl_slot = 1'b0;
      got = srv_data;
   endtask

   task automatic run_frame(input int exp_cn, input int mid_push, input string tag);
      logic [W-1:0] g;
      int exp;
      @(negedge clk); frm_start = 1'b1;
      @(negedge clk); frm_start = 1'b0;
      check({tag, " R7 idle after frame start"}, int'(srv_data), 0);
      slot(1'b1, g); check({tag, " R4 R10 overhead high byte"}, int'(g), (exp_cn >> 8) & 8'hFF);
      slot(1'b1, g); check({tag, " R3 R4 overhead low byte"}, int'(g), exp_cn & 8'hFF);
      slot(1'b1, g); check({tag, " R4 extra overhead slot"}, int'(g), 0);
      for (int i = 0; i < mid_push; i++) push_word();
      for (int j = 1; j <= P; j++) begin
         slot(1'b0, g);
         if (((j * exp_cn) % P) < exp_cn) begin
            exp = int'(mq[mh % 256]);
            mh++;
         end else exp = 0;
         check($sformatf("%s R2 R5 R6 payload pos %0d", tag, j), int'(g), exp);
      end
      slot(1'b0, g); check({tag, " R7 payload beyond P"}, int'(g), 0);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      do_reset();
      @(negedge clk);
      check("R1 reset output zero", int'(srv_data), 0);
      check("R1 reset overflow low", int'(ovf_flag), 0);

      for (int v = 0; v < VEC_N; v++) begin
         for (int n = 0; n < VEC[v][0]; n++) push_word();
         run_frame(VEC[v][1], 0, $sformatf("vec%0d R3", v));
      end

      // R6: words arriving inside the frame leave its count alone; R9: next frame follows
      for (int n = 0; n < 4; n++) push_word();
      run_frame(4, 6, "R6 mid-frame");
      run_frame(6, 0, "R9 step up");

      // R8: fill the buffer, then one more word
      for (int n = 0; n < DEPTH; n++) push_word();
      check("R8 no overflow at exactly full", int'(ovf_flag), 0);
      push_word();
      check("R8 overflow on write to full", int'(ovf_flag), 1);
      run_frame(16, 0, "R8 drain a");
      run_frame(8, 0, "R8 drain b dropped word absent");
      check("R8 overflow sticky", int'(ovf_flag), 1);
      run_frame(0, 0, "R8 empty after drain");

      do_reset();
      @(negedge clk);
      check("R1 overflow cleared by reset", int'(ovf_flag), 0);
      check("R1 output zero after reset", int'(srv_data), 0);
      run_frame(0, 0, "R1 first frame empty");
      for (int n = 0; n < 12; n++) push_word();
      run_frame(12, 0, "R9 start-up step");

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule